// File: doc/BRIEF.md
# Serial Flash Command Executor

This block runs one short serial flash command at a time. Software packs the whole command into a single 32-bit command word: an opcode byte, plus optional address, write-data and read-data phases. Each optional phase has its own enable bit and its own length-minus-one field. Setting bit 0 of the written word starts execution. The block then emits the opcode, the address bytes, the write bytes and the read requests in a fixed order over a byte-wide handshake toward a serial shifter. A busy flag stays high for the whole command.

The address comes from a 32-bit address register and the outgoing data from a lower/upper pair of 32-bit write registers. All three are sampled when the command starts. Returned bytes land in a lower/upper pair of 32-bit read registers. Software waits for busy to drop and then reads both registers. Each byte transfer is a request/acknowledge pair. The shifter may hold off the acknowledge for any number of cycles, and the block waits without changing the request.

Top module: `flash_cmd_exec`

## Requirements
- R1: A command-word write with bit 0 set while idle raises `busy_o` from the next cycle. A write with bit 0 clear starts nothing.
- R2: Command word layout: opcode [31:24], read enable [23], read length-1 [22:20], address enable [19], address length-1 [17:16], write enable [15], write length-1 [14:12]. The opcode is always the first byte sent.
- R3: Phases run in the order opcode, address, write, read, and a disabled phase is skipped. `xfer_rd_o` is 1 only during read-phase bytes.
- R4: The address phase sends (length-1)+1 bytes of the sampled address, most significant of those bytes first.
- R5: The write phase sends (length-1)+1 bytes from {upper, lower}, starting at byte 0 (bits 7:0) of the lower register and continuing into the upper register.
- R6: Read byte k (k = 0..7) is stored in bits 8k+7:8k of {`rdata_hi_o`, `rdata_lo_o`}. Byte 0 is the first byte received.
- R7: Read-register bytes beyond the programmed read length keep their previous contents.
- R8: A command-word write while busy is ignored. The running command completes unchanged and no second command follows.
- R9: `busy_o` falls at the clock edge that accepts the final byte of the last enabled phase. The read registers hold their final values from that cycle on.
- R10: After reset `busy_o` and `xfer_req_o` are 0 and both read registers are 0.
- R11: While `xfer_req_o` is high and `xfer_ack_i` is low, the request, direction and outgoing byte hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command-word write strobe |
| cmd_wdata_i | input | 32 | Command word; bit 0 = execute |
| addr_i | input | 32 | Address register contents |
| wdata_lo_i | input | 32 | Write data, bytes 0-3 |
| wdata_hi_i | input | 32 | Write data, bytes 4-7 |
| busy_o | output | 1 | Command in progress |
| rdata_lo_o | output | 32 | Read data, bytes 0-3 |
| rdata_hi_o | output | 32 | Read data, bytes 4-7 |
| xfer_req_o | output | 1 | Byte transfer request |
| xfer_rd_o | output | 1 | 1 = receive byte, 0 = send byte |
| xfer_tx_o | output | 8 | Byte to send |
| xfer_ack_i | input | 1 | Byte transfer accepted this cycle |
| xfer_rx_i | input | 8 | Received byte, valid with acknowledge |

## Verification
The hardest case to reach from the ports is a command-word write that lands in the middle of a running command. It must be dropped, and the running command must finish byte for byte. The stimulus reaches it by raising the strobe with a different execute word in the same cycle as a read-phase acknowledge. The bench then checks every remaining byte against the original command and confirms the block stays idle afterwards. A short read that follows a full eight-byte read exposes whether the untouched upper bytes survive. Acknowledges are stalled on a rotating pattern so that each phase is seen held across wait cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 32;
  localparam int MAX_DATA = 8;
  localparam int IDX_W    = $clog2(MAX_DATA);
  localparam int ADDR_MAX = WORD_W / BYTE_W;

  typedef enum logic [2:0] {PH_IDLE, PH_OPC, PH_ADDR, PH_WR, PH_RD} phase_e;

  typedef struct packed {
    logic [BYTE_W-1:0] opcode;
    logic              rd_en;
    logic [2:0]        rd_last;
    logic              addr_en;
    logic [1:0]        addr_last;
    logic              wr_en;
    logic [2:0]        wr_last;
  } cmd_t;

  function automatic cmd_t decode_cmd(logic [WORD_W-1:0] w);
    cmd_t c;
    c.opcode    = w[31:24];
    c.rd_en     = w[23];
    c.rd_last   = w[22:20];
    c.addr_en   = w[19];
    c.addr_last = w[17:16];
    c.wr_en     = w[15];
    c.wr_last   = w[14:12];
    return c;
  endfunction

  function automatic phase_e next_phase(phase_e cur, cmd_t c);
    phase_e n;
    n = PH_IDLE;
    unique case (cur)
      PH_OPC:  n = c.addr_en ? PH_ADDR : c.wr_en ? PH_WR : c.rd_en ? PH_RD : PH_IDLE;
      PH_ADDR: n = c.wr_en ? PH_WR : c.rd_en ? PH_RD : PH_IDLE;
      PH_WR:   n = c.rd_en ? PH_RD : PH_IDLE;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/fcx_sequencer.sv
module fcx_sequencer
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  input  logic              ack_i,
  output cmd_t              cmd_o,
  output phase_e            phase_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o
);
  cmd_t             cmd_q;
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             last;

  always_comb begin
    unique case (phase_q)
      PH_OPC:  last = 1'b1;
      PH_ADDR: last = (idx_q == IDX_W'(cmd_q.addr_last));
      PH_WR:   last = (idx_q == cmd_q.wr_last);
      PH_RD:   last = (idx_q == cmd_q.rd_last);
      default: last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else if (start_i) begin
      cmd_q   <= decode_cmd(cmd_word_i);
      phase_q <= PH_OPC;
      idx_q   <= '0;
    end else if (phase_q != PH_IDLE && ack_i) begin
      if (last) begin
        phase_q <= next_phase(phase_q, cmd_q);
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign cmd_o   = cmd_q;
  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign busy_o  = (phase_q != PH_IDLE);

  assert_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && phase_q == PH_OPC && idx_q == '0));
  assert_wr_index_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WR) |-> (cmd_q.wr_en && idx_q <= cmd_q.wr_last));
  assert_rd_index_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RD) |-> (cmd_q.rd_en && idx_q <= cmd_q.rd_last));
endmodule

// File: rtl/fcx_tx_mux.sv
module fcx_tx_mux
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_lo_i,
  input  logic [WORD_W-1:0] wdata_hi_i,
  input  cmd_t              cmd_i,
  input  phase_e            phase_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] tx_o
);
  logic [ADDR_MAX-1:0][BYTE_W-1:0] addr_q;
  logic [MAX_DATA-1:0][BYTE_W-1:0] wbuf_q;
  logic [1:0]                      addr_sel;

  // operands are frozen at start so software may reload them mid-command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wbuf_q <= '0;
    end else if (start_i) begin
      addr_q <= addr_i;
      wbuf_q <= {wdata_hi_i, wdata_lo_i};
    end
  end

  assign addr_sel = cmd_i.addr_last - idx_i[1:0];

  always_comb begin
    unique case (phase_i)
      PH_OPC:  tx_o = cmd_i.opcode;
      PH_ADDR: tx_o = addr_q[addr_sel];
      PH_WR:   tx_o = wbuf_q[idx_i];
      default: tx_o = '0;
    endcase
  end
endmodule

// File: rtl/fcx_rx_capture.sv
module fcx_rx_capture
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic [WORD_W-1:0] rdata_lo_o,
  output logic [WORD_W-1:0] rdata_hi_o
);
  logic [MAX_DATA-1:0][BYTE_W-1:0] rbuf_q;

  for (genvar g = 0; g < MAX_DATA; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rbuf_q[g] <= '0;
      else if (capture_i && idx_i == IDX_W'(g)) rbuf_q[g] <= rx_i;
    end
  end

  assign {rdata_hi_o, rdata_lo_o} = rbuf_q;

  assert_untouched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rbuf_q));
  assert_single_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> ($countones(rbuf_q ^ $past(rbuf_q)) <= BYTE_W));
endmodule

// File: rtl/flash_cmd_exec.sv
module flash_cmd_exec
  import flash_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_lo_i,
  input  logic [31:0] wdata_hi_i,
  output logic        busy_o,
  output logic [31:0] rdata_lo_o,
  output logic [31:0] rdata_hi_o,
  output logic        xfer_req_o,
  output logic        xfer_rd_o,
  output logic [7:0]  xfer_tx_o,
  input  logic        xfer_ack_i,
  input  logic [7:0]  xfer_rx_i
);
  cmd_t             cmd_q;
  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic             busy;
  logic             start;

  assign start = cmd_we_i && cmd_wdata_i[0] && !busy;

  fcx_sequencer u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_word_i(cmd_wdata_i),
    .ack_i     (xfer_ack_i),
    .cmd_o     (cmd_q),
    .phase_o   (phase),
    .idx_o     (idx),
    .busy_o    (busy)
  );

  fcx_tx_mux u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .addr_i    (addr_i),
    .wdata_lo_i(wdata_lo_i),
    .wdata_hi_i(wdata_hi_i),
    .cmd_i     (cmd_q),
    .phase_i   (phase),
    .idx_i     (idx),
    .tx_o      (xfer_tx_o)
  );

  fcx_rx_capture u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (phase == PH_RD && xfer_ack_i),
    .idx_i     (idx),
    .rx_i      (xfer_rx_i),
    .rdata_lo_o(rdata_lo_o),
    .rdata_hi_o(rdata_hi_o)
  );

  assign busy_o     = busy;
  assign xfer_req_o = busy;
  assign xfer_rd_o  = (phase == PH_RD);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_ack_i) |=>
      (xfer_req_o && $stable(xfer_tx_o) && $stable(xfer_rd_o)));
  assert_ignore_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_we_i) |=> $stable(cmd_q));
  assert_end_on_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(xfer_ack_i));
  assert_no_exec_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(cmd_we_i && cmd_wdata_i[0])) |=> !busy_o);
endmodule

// File: tb/flash_cmd_exec_test.sv
`timescale 1ns/100ps
module flash_cmd_exec_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0, addr = '0, wlo = '0, whi = '0;
  logic        busy, xreq, xrd, xack = 1'b0;
  logic [31:0] rlo, rhi;
  logic [7:0]  xtx, xrx = '0;

  always #2.5 clk = ~clk;

  flash_cmd_exec uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .addr_i(addr), .wdata_lo_i(wlo), .wdata_hi_i(whi), .busy_o(busy),
    .rdata_lo_o(rlo), .rdata_hi_o(rhi), .xfer_req_o(xreq), .xfer_rd_o(xrd),
    .xfer_tx_o(xtx), .xfer_ack_i(xack), .xfer_rx_i(xrx)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic        ren;
    logic [2:0]  rlen;
    logic        aen;
    logic [1:0]  alen;
    logic        wen;
    logic [2:0]  wlen;
    logic [31:0] a;
    logic [31:0] wl;
    logic [31:0] wh;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h9F, 1'b1, 3'd2, 1'b0, 2'd0, 1'b0, 3'd0, 32'h0, 32'h0, 32'h0},
    '{8'h06, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 32'h0, 32'h0, 32'h0},
    '{8'hD8, 1'b0, 3'd0, 1'b1, 2'd2, 1'b0, 3'd0, 32'h00123456, 32'h0, 32'h0},
    '{8'h02, 1'b0, 3'd0, 1'b1, 2'd3, 1'b1, 3'd4, 32'hA1B2C3D4, 32'h44332211, 32'h88776655},
    '{8'h0B, 1'b1, 3'd7, 1'b1, 2'd3, 1'b1, 3'd7, 32'h01020304, 32'hDDCCBBAA, 32'h1122EEFF},
    '{8'h05, 1'b1, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 32'h0, 32'h0, 32'h0},
    '{8'h35, 1'b1, 3'd4, 1'b1, 2'd0, 1'b0, 3'd0, 32'h0000005A, 32'h0, 32'h0}
  };

  int n_chk = 0, n_fail = 0;
  logic [63:0] rd_model = '0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input vec_t v, input int seed, input int inj);
    logic [7:0] eb [24];
    bit         ed [24];
    string      et [24];
    int         n = 0;
    int         rk = 0;
    logic [7:0] prev;
    logic [7:0] rv;
    eb[n] = v.op; ed[n] = 1'b0; et[n] = "R2"; n++;
    if (v.aen) for (int k = 0; k <= int'(v.alen); k++) begin
      eb[n] = 8'(v.a >> (8 * (int'(v.alen) - k))); ed[n] = 1'b0; et[n] = "R4"; n++;
    end
    if (v.wen) for (int k = 0; k <= int'(v.wlen); k++) begin
      eb[n] = 8'({v.wh, v.wl} >> (8 * k)); ed[n] = 1'b0; et[n] = "R5"; n++;
    end
    if (v.ren) for (int k = 0; k <= int'(v.rlen); k++) begin
      eb[n] = 8'h00; ed[n] = 1'b1; et[n] = "R6"; n++;
    end
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_wdata = {v.op, v.ren, v.rlen, v.aen, 1'b0, v.alen, v.wen, v.wlen, 11'h0, 1'b1};
    addr = v.a; wlo = v.wl; whi = v.wh;
    @(negedge clk);
    cmd_we = 1'b0;
    addr = ~v.a; wlo = ~v.wl; whi = ~v.wh;  // late changes must not matter
    check("R1 busy after execute", 64'(busy), 64'd1);
    for (int i = 0; i < n; i++) begin
      check("R3 request", 64'(xreq), 64'd1);
      check("R3 direction", 64'(xrd), 64'(ed[i]));
      if (!ed[i]) check(et[i], 64'(xtx), 64'(eb[i]));
      if ((i + seed) % 3 == 0) begin
        prev = xtx;
        xack = 1'b0;
        @(negedge clk);
        check("R11 held", {55'd0, xreq, xtx}, {55'd0, 1'b1, prev});
      end
      rv = 8'(8'hC1 + seed * 16 + i);
      xack = 1'b1; xrx = rv;
      if (ed[i]) begin
        rd_model[8*rk +: 8] = rv;
        rk++;
      end
      if (i == inj) begin
        cmd_we = 1'b1;
        cmd_wdata = 32'h06_8B_F0_01;
      end
      @(negedge clk);
      xack = 1'b0; cmd_we = 1'b0;
    end
    check("R9 busy cleared", 64'(busy), 64'd0);
    check("R6 R7 read data", {rhi, rlo}, rd_model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 actual=busy expected=idle");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 busy in reset", 64'(busy), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {62'd0, busy, xreq}, 64'd0);
    check("R10 read regs zero", {rhi, rlo}, 64'd0);

    // command write without the execute bit
    cmd_we = 1'b1; cmd_wdata = 32'h9F_A0_00_00;
    @(negedge clk);
    cmd_we = 1'b0;
    check("R1 no execute bit", {62'd0, busy, xreq}, 64'd0);
    @(negedge clk);
    check("R1 still idle", 64'(busy), 64'd0);

    for (int v = 0; v < NV; v++) run_cmd(VECS[v], v, -1);

    // execute request arriving mid-command is dropped
    run_cmd(VECS[0], 5, 2);
    @(negedge clk);
    check("R8 no second command", {62'd0, busy, xreq}, 64'd0);
    run_cmd(VECS[3], 1, 4);
    @(negedge clk);
    check("R8 idle after write cmd", 64'(busy), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule